// File: doc/BRIEF.md
# Flash Block Write-Protect Gate

This block stands in front of the program and erase engines of a block-organised flash array. It decides, for every write request, whether the addressed block may be altered. Two active-low hardware pins feed it. One pin guards only the topmost block, the boot block. The other pin guards every other block. Each block also has a software lock bit. A block is protected when its pin is held low or when its lock bit is set. Either condition alone is enough.

A permitted request gives a one-cycle start pulse. The block then stays busy until the engine reports that the operation is done. A refused request gives a one-cycle refusal pulse and starts nothing. The lock bits can be written and read back. Readback always returns the stored bit, even when a low pin overrides it.

The pins are treated as asynchronous. They pass through a short synchronizer. That synchronizer is frozen for as long as an operation is running, so a pin that moves mid-operation has no effect until the operation ends.

Top module: `wp_gate`

## Requirements
- R1: After reset every lock bit reads back as 1, and grant, reject and busy are all 0. A request to any block after reset is therefore rejected while both pins are high.
- R2: While boot_lock_n is low, a request to the top block (index NUM_BLOCKS-1) is rejected whatever that block's lock bit holds.
- R3: While wr_prot_n is low, a request to any block below the top block is rejected whatever its lock bit holds.
- R4: While the pin that covers a block is high, that block's request is rejected exactly when its lock bit is 1.
- R5: The pins act independently. boot_lock_n has no effect on blocks below the top, and wr_prot_n has no effect on the top block.
- R6: Lock readback returns the stored bit one cycle after lock_rsel is presented. A bit cleared to 0 while its pin is low reads 0, but the block still stays protected.
- R7: When the block is idle, a request produces exactly one of two results one cycle later. A permitted request produces a single-cycle grant and sets busy. A refused request produces a single-cycle reject and leaves busy at 0.
- R8: While busy is 1, requests produce neither grant nor reject. Busy falls on the clock edge where op_done is sampled high. op_done while idle has no effect.
- R9: Pin levels pass through a two-stage synchronizer that is frozen while busy. A pin change made during an operation is not seen by the first request after the operation ends. A pin change is seen by requests made three or more idle cycles after it.
- R10: A lock write applies from the next cycle. A request in the same cycle as a write to its block is decided on the old bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_lock_n | input | 1 | Active-low protect pin for the top block |
| wr_prot_n | input | 1 | Active-low protect pin for all other blocks |
| req_valid | input | 1 | Program or erase request strobe |
| req_blk | input | IDX_W | Block index of the request |
| op_done | input | 1 | Engine reports the running operation finished |
| lock_we | input | 1 | Lock bit write enable |
| lock_wsel | input | IDX_W | Block whose lock bit is written |
| lock_wdata | input | 1 | Lock value to write (1 = locked) |
| lock_rsel | input | IDX_W | Block whose lock bit is read back |
| lock_rdata | output | 1 | Registered stored lock bit |
| grant | output | 1 | One-cycle pulse: operation may start |
| reject | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | An operation is in flight |

## Verification
Suppose a lock bit is corrupted or the wrong pin is steered to a block. The very next request to that block then shows the opposite pulse, grant where reject is due or the reverse, one cycle after the request. A stale synchronizer shows up within three idle cycles of a pin change as a wrong decision. A stuck busy shows as missing pulses on every later request. A lost lock write shows on the readback port one cycle after selection. It also shows in the decision of the next request.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

  // Snapshot of the two protect pins, both active low.
  typedef struct packed {
    logic boot_n;
    logic wprot_n;
  } pin_pair_t;

  // Safe default: both pins read as asserted (protecting).
  localparam pin_pair_t PINS_SAFE = '{boot_n: 1'b0, wprot_n: 1'b0};

  // A block is protected when its pin is low or its lock bit is set.
  function automatic logic blk_protected(input logic pin_n, input logic lock_bit);
    return (~pin_n) | lock_bit;
  endfunction

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync
  import wp_gate_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      freeze,
  input  pin_pair_t pins_in,
  output pin_pair_t pins_out
);

  pin_pair_t chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[s] <= PINS_SAFE;
        end else if (!freeze) begin
          if (s == 0) chain[s] <= pins_in;
          else        chain[s] <= chain[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign pins_out = chain[STAGES-1];

endmodule

// File: rtl/wp_lock_regs.sv
module wp_lock_regs #(
  parameter int NUM_BLOCKS = 8,
  parameter int IDX_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IDX_W-1:0]      wsel,
  input  logic                  wdata,
  input  logic [IDX_W-1:0]      rsel,
  output logic                  rdata,
  output logic [NUM_BLOCKS-1:0] locks
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BLOCKS - 1);

  logic [NUM_BLOCKS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '1;
    end else if (we && (wsel <= LAST)) begin
      bits_q[wsel] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= 1'b0;
    else if (rsel <= LAST)  rdata <= bits_q[rsel];
    else                    rdata <= 1'b1;
  end

  assign locks = bits_q;

endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_gate_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int IDX_W      = 3
) (
  input  pin_pair_t             pins,
  input  logic [NUM_BLOCKS-1:0] locks,
  input  logic [IDX_W-1:0]      blk,
  output logic                  deny
);

  localparam int SLOTS = 1 << IDX_W;
  localparam int TOP   = NUM_BLOCKS - 1;

  logic [SLOTS-1:0] eff;

  genvar i;
  generate
    for (i = 0; i < SLOTS; i++) begin : g_blk
      if (i == TOP) begin : g_top
        assign eff[i] = blk_protected(pins.boot_n, locks[i]);
      end else if (i < TOP) begin : g_rest
        assign eff[i] = blk_protected(pins.wprot_n, locks[i]);
      end else begin : g_void
        assign eff[i] = 1'b1;
      end
    end
  endgenerate

  assign deny = eff[blk];

endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_gate_pkg::*;
#(
  parameter  int FLASH_KB    = 512,
  parameter  int BLOCK_KB    = 64,
  parameter  int SYNC_STAGES = 2,
  localparam int NUM_BLOCKS  = FLASH_KB / BLOCK_KB,
  localparam int IDX_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_lock_n,
  input  logic             wr_prot_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_blk,
  input  logic             op_done,
  input  logic             lock_we,
  input  logic [IDX_W-1:0] lock_wsel,
  input  logic             lock_wdata,
  input  logic [IDX_W-1:0] lock_rsel,
  output logic             lock_rdata,
  output logic             grant,
  output logic             reject,
  output logic             busy
);

  pin_pair_t             pins_raw;
  pin_pair_t             pins_s;
  logic [NUM_BLOCKS-1:0] locks;
  logic                  deny;
  logic                  boot_s;
  logic                  wprot_s;

  assign pins_raw = '{boot_n: boot_lock_n, wprot_n: wr_prot_n};
  assign boot_s   = pins_s.boot_n;
  assign wprot_s  = pins_s.wprot_n;

  wp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .freeze   (busy),
    .pins_in  (pins_raw),
    .pins_out (pins_s)
  );

  wp_lock_regs #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_locks (
    .clk   (clk),
    .rst   (rst),
    .we    (lock_we),
    .wsel  (lock_wsel),
    .wdata (lock_wdata),
    .rsel  (lock_rsel),
    .rdata (lock_rdata),
    .locks (locks)
  );

  wp_decide #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_decide (
    .pins  (pins_s),
    .locks (locks),
    .blk   (req_blk),
    .deny  (deny)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      grant  <= 1'b0;
      reject <= 1'b0;
    end else begin
      grant  <= 1'b0;
      reject <= 1'b0;
      if (busy) begin
        if (op_done) busy <= 1'b0;
      end else if (req_valid) begin
        if (deny) begin
          reject <= 1'b1;
        end else begin
          grant <= 1'b1;
          busy  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
  parameter int IDX_W = 3,
  parameter int TOP   = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [IDX_W-1:0] req_blk,
  input logic             op_done,
  input logic             grant,
  input logic             reject,
  input logic             busy,
  input logic             boot_s,
  input logic             wprot_s
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TOP);

  AST_TOP_PIN_DENY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_blk == TOP_IDX && !boot_s) |=> reject); // R2
  AST_REST_PIN_DENY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_blk < TOP_IDX && !wprot_s) |=> reject); // R3
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grant && reject)); // R7
  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant); // R7
  AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
    grant |-> busy); // R7
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    reject |-> !busy); // R7
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!grant && !reject)); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busy && op_done) |=> !busy); // R8
  AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(boot_s) && $stable(wprot_s))); // R9

endmodule

bind wp_gate wp_gate_chk #(.IDX_W(IDX_W), .TOP(NUM_BLOCKS - 1)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_blk   (req_blk),
  .op_done   (op_done),
  .grant     (grant),
  .reject    (reject),
  .busy      (busy),
  .boot_s    (boot_s),
  .wprot_s   (wprot_s)
);

// File: tb/tb_wp_gate.sv
module tb_wp_gate;

  localparam int NB  = 8;
  localparam int IW  = 3;
  localparam int TOP = NB - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          boot_lock_n = 1'b1;
  logic          wr_prot_n = 1'b1;
  logic          req_valid = 1'b0;
  logic [IW-1:0] req_blk = '0;
  logic          op_done = 1'b0;
  logic          lock_we = 1'b0;
  logic [IW-1:0] lock_wsel = '0;
  logic          lock_wdata = 1'b0;
  logic [IW-1:0] lock_rsel = '0;
  logic          lock_rdata;
  logic          grant;
  logic          reject;
  logic          busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  wp_gate dut (
    .clk(clk), .rst(rst), .boot_lock_n(boot_lock_n), .wr_prot_n(wr_prot_n),
    .req_valid(req_valid), .req_blk(req_blk), .op_done(op_done),
    .lock_we(lock_we), .lock_wsel(lock_wsel), .lock_wdata(lock_wdata),
    .lock_rsel(lock_rsel), .lock_rdata(lock_rdata),
    .grant(grant), .reject(reject), .busy(busy)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_lock(input int blk, input logic val);
    @(negedge clk);
    lock_we = 1'b1; lock_wsel = IW'(blk); lock_wdata = val;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic read_lock(input int blk, input logic exp, input string tag);
    @(negedge clk);
    lock_rsel = IW'(blk);
    @(negedge clk);
    check(tag, {3'b0, lock_rdata}, {3'b0, exp});
  endtask

  // Request one block; result visible one cycle later as {grant,reject}.
  task automatic request(input int blk, input logic exp_deny, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_blk = IW'(blk);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {2'b0, grant, reject}, {2'b0, ~exp_deny, exp_deny});
    check({tag, " busy"}, {3'b0, busy}, {3'b0, ~exp_deny});
    if (grant) begin
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
    end
  endtask

  task automatic set_pins(input logic b, input logic w);
    @(negedge clk);
    boot_lock_n = b; wr_prot_n = w;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 outputs", {1'b0, grant, reject, busy}, 4'h0);
    for (int b = 0; b < NB; b++) read_lock(b, 1'b1, "R1 lock readback");
    repeat (3) @(negedge clk);
    request(3, 1'b1, "R1 default locked");

    // R2 R3 R4 R5 R6: sweep pins x block x lock value
    for (int pb = 0; pb < 2; pb++) begin
      for (int pw = 0; pw < 2; pw++) begin
        set_pins(pb[0], pw[0]);
        for (int b = 0; b < NB; b++) begin
          for (int lk = 0; lk < 2; lk++) begin
            logic pin_n;
            logic exp;
            pin_n = (b == TOP) ? pb[0] : pw[0];
            exp   = ~pin_n | lk[0];
            write_lock(b, lk[0]);
            read_lock(b, lk[0], "R6 stored bit");
            if (b == TOP)
              request(b, exp, pin_n ? "R4 R5 top pin high" : "R2 top pin low");
            else
              request(b, exp, pin_n ? "R4 R5 rest pin high" : "R3 rest pin low");
          end
        end
      end
    end

    // R8: busy ignores requests, op_done idle ignored
    set_pins(1'b1, 1'b1);
    write_lock(1, 1'b0);
    write_lock(2, 1'b1);
    @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    check("R8 idle op_done", {3'b0, busy}, 4'h0);
    @(negedge clk); req_valid = 1'b1; req_blk = 3'd1;
    @(negedge clk); req_valid = 1'b0;
    check("R7 grant", {1'b0, grant, reject, busy}, 4'b0101);
    @(negedge clk);
    check("R7 single pulse", {1'b0, grant, reject, busy}, 4'b0001);
    for (int k = 0; k < 3; k++) begin
      req_valid = 1'b1; req_blk = IW'(k == 1 ? 2 : 1);
      @(negedge clk);
      check("R8 quiet while busy", {1'b0, grant, reject, busy}, 4'b0001);
    end
    req_valid = 1'b0;

    // R9: pin drop mid-operation not seen by first request after done
    wr_prot_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 still busy", {3'b0, busy}, 4'h1);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    check("R8 done clears", {3'b0, busy}, 4'h0);
    req_valid = 1'b1; req_blk = 3'd1;
    @(negedge clk); req_valid = 1'b0;
    check("R9 frozen pin", {2'b0, grant, reject}, 4'b0010);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    repeat (3) @(negedge clk);
    request(1, 1'b1, "R9 pin seen later");

    // R6: cleared bit under low pin reads 0 yet stays protected
    write_lock(4, 1'b0);
    read_lock(4, 1'b0, "R6 cleared readback");
    request(4, 1'b1, "R6 still protected");

    // R10: same-cycle write decided on old bit
    set_pins(1'b1, 1'b1);
    write_lock(5, 1'b1);
    @(negedge clk);
    lock_we = 1'b1; lock_wsel = 3'd5; lock_wdata = 1'b0;
    req_valid = 1'b1; req_blk = 3'd5;
    @(negedge clk);
    lock_we = 1'b0; req_valid = 1'b0;
    check("R10 old bit used", {2'b0, grant, reject}, 4'b0001);
    request(5, 1'b0, "R10 new bit next cycle");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule